// File: doc/BRIEF.md
# Serial Flash Boot Loader

This block is the device-side master that fetches a configuration image from a four-wire serial flash after power-up. It holds a ready flag low for a programmable power-on delay, then selects the flash, clocks out a read command with a zero start address, and assembles the returned bit stream into bytes. Each byte is handed to a downstream sink with a one-cycle strobe.

Once the last image bit arrives, the flash is released and a done flag goes high. An initialization phase of a fixed number of serial-clock periods then runs, and at its end the block enters user mode. The serial clock is divided down from the system clock. The image length and all delays are parameters. The output enable for the user I/O stays in its high-impedance state until user mode begins.

Top module: `as_config_loader`

## Requirements
- R1: While reset is asserted, the ready, done and user-mode outputs are low, chip select is high, the serial clock is low, the byte strobe is low and the I/O high-impedance enable is high.
- R2: Reset passes through a two-stage synchronizer. The ready output goes high exactly POR_CYCLES system cycles after the synchronized release, which is POR_CYCLES+2 rising edges after the reset input rises. Chip select is never low while ready is low.
- R3: The serial clock has a period of 2*HALF_DIV system cycles, with a high phase of HALF_DIV cycles. Its first rising edge comes HALF_DIV cycles after chip select falls. It stays low whenever chip select is high.
- R4: The first 32 bits sent on the command line are the opcode 0x03 followed by a 24-bit address of zero, most significant bit first. The command line changes only when the serial clock falls.
- R5: Data is sampled on serial-clock rising edges after the 32 command bits. Each group of 8 bits forms a byte with the first bit as bit 7. The byte is presented with a strobe that is high for exactly one system cycle.
- R6: Exactly IMAGE_BYTES bytes are delivered. Chip select rises on the serial-clock falling edge that follows the last sampled bit, and no further serial-clock pulses follow.
- R7: The done output rises in the same cycle that chip select is released, and it stays high until reset.
- R8: The user-mode output rises after INIT_CYCLES internal serial-clock periods, counted to the last rising edge, which is (2*INIT_CYCLES-1)*HALF_DIV system cycles after done rises. The serial clock pin stays low during this phase.
- R9: The I/O high-impedance enable is high from reset until user mode and low from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flash_sck_o | output | 1 | Serial clock to flash |
| flash_cs_n_o | output | 1 | Flash chip select, active low |
| flash_mosi_o | output | 1 | Command/address line into flash |
| flash_miso_i | input | 1 | Data line from flash |
| img_byte_o | output | 8 | Assembled image byte |
| img_valid_o | output | 1 | One-cycle strobe for img_byte_o |
| cfg_ready_o | output | 1 | Low while the power-on delay runs |
| cfg_done_o | output | 1 | High once the whole image has been read |
| user_mode_o | output | 1 | High once initialization has finished |
| io_hiz_o | output | 1 | High-impedance enable for user I/O |

## Verification
Two image patterns are streamed from a flash model. The first is a sequence of distinct pseudo-random bytes, which exposes lost, duplicated or reordered bytes. The second cycles through 0x80, 0x01, 0xFF and 0x00, which separates a correct bit order from a reversed one and exposes a stuck data bit. Each run also checks the captured command word, the length of each high phase on the serial clock, and the exact cycle counts of the power-on delay and the initialization phase. A reset between the two runs shows that the block restarts cleanly.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [2:0] {
    ST_POR,
    ST_CMD,
    ST_DATA,
    ST_INIT,
    ST_USER
  } boot_st_e;

  localparam logic [7:0] RD_OPCODE = 8'h03;
  localparam int ADDR_BITS = 24;
  localparam int HDR_BITS  = 8 + ADDR_BITS;
endpackage

// File: rtl/boot_clkdiv.sv
module boot_clkdiv #(
  parameter int HALF_DIV = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          tick;

  assign tick   = run_i && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  // R3: the divided clock only moves while the divider is running
  p_sclk_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $past(run_i));
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_pkg::*;
#(
  parameter int POR_CYCLES  = 25_000_000,
  parameter int INIT_CYCLES = 136
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rise_i,
  input  logic     fall_i,
  input  logic     hdr_done_i,
  input  logic     img_done_i,
  output boot_st_e st_o
);
  localparam int POR_W  = $clog2(POR_CYCLES + 1);
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);

  boot_st_e          st_q, st_d;
  logic [POR_W-1:0]  por_q, por_d;
  logic [INIT_W-1:0] init_q, init_d;

  assign st_o = st_q;

  always_comb begin
    st_d   = st_q;
    por_d  = por_q;
    init_d = init_q;
    unique case (st_q)
      ST_POR: begin
        if (por_q == POR_W'(POR_CYCLES - 1)) st_d = ST_CMD;
        else                                 por_d = por_q + 1'b1;
      end
      ST_CMD:  if (hdr_done_i) st_d = ST_DATA;
      ST_DATA: begin
        if (img_done_i && fall_i) begin
          st_d   = ST_INIT;
          init_d = '0;
        end
      end
      ST_INIT: begin
        if (rise_i) begin
          if (init_q == INIT_W'(INIT_CYCLES - 1)) st_d = ST_USER;
          else                                    init_d = init_q + 1'b1;
        end
      end
      ST_USER: st_d = ST_USER;
      default: st_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_POR;
      por_q  <= '0;
      init_q <= '0;
    end else begin
      st_q   <= st_d;
      por_q  <= por_d;
      init_q <= init_d;
    end
  end

  // R2: once the power-on delay has ended it never restarts without reset
  p_no_return_por_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_POR) |=> (st_q != ST_POR));
  // R8: the initialization phase only advances on a serial rising tick
  p_init_waits_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_INIT && !rise_i) |=> (st_q == ST_INIT));
endmodule

// File: rtl/boot_shift.sv
module boot_shift
  import boot_pkg::*;
#(
  parameter int IMAGE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  boot_st_e   st_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       data_i,
  output logic       cmd_o,
  output logic       hdr_done_o,
  output logic       img_done_o,
  output logic [7:0] byte_o,
  output logic       vld_o
);
  localparam int TOTAL   = IMAGE_BYTES * 8;
  localparam int CNT_MAX = (TOTAL > HDR_BITS) ? TOTAL : HDR_BITS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [HDR_BITS-1:0] hdr_q, hdr_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [6:0]          acc_q, acc_d;
  logic [7:0]          byte_q, byte_d;
  logic                vld_q, vld_d;

  assign cmd_o      = hdr_q[HDR_BITS-1];
  assign hdr_done_o = (st_i == ST_CMD) && rise_i && (cnt_q == CNT_W'(HDR_BITS - 1));
  assign img_done_o = (st_i == ST_DATA) && (cnt_q == CNT_W'(TOTAL));
  assign byte_o     = byte_q;
  assign vld_o      = vld_q;

  always_comb begin
    hdr_d  = hdr_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    unique case (st_i)
      ST_CMD: begin
        if (fall_i) hdr_d = {hdr_q[HDR_BITS-2:0], 1'b0};
        if (rise_i) cnt_d = hdr_done_o ? '0 : cnt_q + 1'b1;
      end
      ST_DATA: begin
        if (rise_i && !img_done_o) begin
          acc_d = {acc_q[5:0], data_i};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q[2:0] == 3'd7) begin
            byte_d = {acc_q, data_i};
            vld_d  = 1'b1;
          end
        end
      end
      default: begin
        hdr_d = {RD_OPCODE, {ADDR_BITS{1'b0}}};
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q  <= {RD_OPCODE, {ADDR_BITS{1'b0}}};
      cnt_q  <= '0;
      acc_q  <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      hdr_q  <= hdr_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

  // R5: the byte strobe never lasts two cycles
  p_vld_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  // R6: no bit is taken once the whole image has been received
  p_no_extra_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    img_done_o |=> (cnt_q == CNT_W'(TOTAL)));
endmodule

// File: rtl/as_config_loader.sv
module as_config_loader
  import boot_pkg::*;
#(
  parameter int HALF_DIV    = 7,
  parameter int POR_CYCLES  = 25_000_000,
  parameter int IMAGE_BYTES = 16,
  parameter int INIT_CYCLES = 136
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       flash_sck_o,
  output logic       flash_cs_n_o,
  output logic       flash_mosi_o,
  input  logic       flash_miso_i,
  output logic [7:0] img_byte_o,
  output logic       img_valid_o,
  output logic       cfg_ready_o,
  output logic       cfg_done_o,
  output logic       user_mode_o,
  output logic       io_hiz_o
);
  logic [1:0] rs_q;
  logic       srst_n;
  boot_st_e   st;
  logic       run, xfer, sclk_int, rise_p, fall_p, hdr_done, img_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  assign xfer = (st == ST_CMD) || (st == ST_DATA);
  assign run  = xfer || (st == ST_INIT);

  boot_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(srst_n), .run_i(run),
    .sclk_o(sclk_int), .rise_o(rise_p), .fall_o(fall_p)
  );

  boot_seq #(.POR_CYCLES(POR_CYCLES), .INIT_CYCLES(INIT_CYCLES)) u_seq (
    .clk(clk), .rst_n(srst_n), .rise_i(rise_p), .fall_i(fall_p),
    .hdr_done_i(hdr_done), .img_done_i(img_done), .st_o(st)
  );

  boot_shift #(.IMAGE_BYTES(IMAGE_BYTES)) u_shift (
    .clk(clk), .rst_n(srst_n), .st_i(st), .rise_i(rise_p), .fall_i(fall_p),
    .data_i(flash_miso_i), .cmd_o(flash_mosi_o), .hdr_done_o(hdr_done),
    .img_done_o(img_done), .byte_o(img_byte_o), .vld_o(img_valid_o)
  );

  assign flash_sck_o  = sclk_int && xfer;
  assign flash_cs_n_o = !xfer;
  assign cfg_ready_o  = (st != ST_POR);
  assign cfg_done_o   = (st == ST_INIT) || (st == ST_USER);
  assign user_mode_o  = (st == ST_USER);
  assign io_hiz_o     = (st != ST_USER);

  // R2: the flash is never selected during the power-on delay
  p_cs_needs_ready_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !flash_cs_n_o |-> cfg_ready_o);
  // R4: the command line holds steady while the serial clock is high
  p_cmd_on_fall_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (flash_sck_o && $past(flash_sck_o)) |-> $stable(flash_mosi_o));
  // R7: done is sticky
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_done_o |=> cfg_done_o);
  // R8: user mode implies done
  p_user_after_done_r8: assert property (@(posedge clk) disable iff (!srst_n)
    user_mode_o |-> cfg_done_o);
endmodule

// File: tb/as_config_loader_tb.sv
module as_config_loader_tb;
  localparam int HALF  = 7;
  localparam int POR   = 40;
  localparam int BYTES = 6;
  localparam int INIT  = 136;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miso = 1'b0;
  logic sck, cs_n, mosi, valid, ready, done, user, hiz;
  logic [7:0] byte_out;

  int errs = 0, checks = 0;
  int nbits = 0, didx = 0, pat = 0, rx_cnt = 0;
  int dbl_err = 0, hiz_err = 0, idle_err = 0, per_err = 0, hi_len = 0;
  logic [31:0] hdr_cap = '0;
  logic vld_prev = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  as_config_loader #(.HALF_DIV(HALF), .POR_CYCLES(POR), .IMAGE_BYTES(BYTES),
                     .INIT_CYCLES(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .flash_sck_o(sck), .flash_cs_n_o(cs_n),
    .flash_mosi_o(mosi), .flash_miso_i(miso), .img_byte_o(byte_out),
    .img_valid_o(valid), .cfg_ready_o(ready), .cfg_done_o(done),
    .user_mode_o(user), .io_hiz_o(hiz)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] img_byte(input int sel, input int idx);
    if (sel == 0) return 8'(idx * 59) ^ 8'h5A;
    case (idx % 4)
      0: return 8'h80;
      1: return 8'h01;
      2: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  // flash model: latch command bits on rising edges
  always @(posedge sck) begin
    if (!cs_n && nbits < 32) begin
      hdr_cap = {hdr_cap[30:0], mosi};
      nbits++;
    end
  end

  // flash model / scoreboard driver: present data on falling edges
  always @(negedge sck) begin : drv
    logic [7:0] fb;
    if (nbits >= 32 && didx < BYTES * 8) begin
      fb = img_byte(pat, didx / 8);
      if (didx % 8 == 0) exp_q.push_back(fb);
      miso = fb[7 - (didx % 8)];
      didx++;
    end
  end

  // monitor
  always @(negedge clk) begin : mon
    logic [7:0] e;
    if (rst_n) begin
      if (valid) begin
        rx_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected byte", int'(byte_out), -1);
        else begin
          e = exp_q.pop_front();
          check(byte_out == e, "R5 byte value", int'(byte_out), int'(e));
        end
      end
      if (vld_prev && valid) dbl_err++;
      vld_prev = valid;
      if (user == hiz) hiz_err++;
      if (sck && cs_n) idle_err++;
      if (sck) hi_len++;
      else begin
        if (hi_len != 0 && hi_len != HALF) per_err++;
        hi_len = 0;
      end
    end
  end

  task automatic run_image(input int sel);
    int n;
    pat = sel; nbits = 0; didx = 0; hdr_cap = '0; miso = 1'b0; rx_cnt = 0;
    dbl_err = 0; hiz_err = 0; idle_err = 0; per_err = 0; hi_len = 0;
    exp_q.delete();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!ready && !done && !user, "R1 flags low in reset", {ready, done, user}, 0);
    check(cs_n && !sck && !valid, "R1 flash idle in reset", {cs_n, sck, valid}, 4);
    check(hiz, "R1 io hiz in reset", hiz, 1);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      if (!ready) n++;
    end while (!ready);
    check(n == POR + 1, "R2 power-on delay", n, POR + 1);
    check(!cs_n && !sck, "R3 select then clock low", {cs_n, sck}, 0);
    while (!done) @(negedge clk);
    check(cs_n, "R7 done with cs release", cs_n, 1);
    check(hdr_cap == 32'h0300_0000 && nbits == 32, "R4 command word", int'(hdr_cap), 32'h0300_0000);
    check(rx_cnt == BYTES, "R6 byte count", rx_cnt, BYTES);
    check(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
    n = 0;
    while (!user) begin
      n++;
      @(negedge clk);
    end
    check(n == (2 * INIT - 1) * HALF, "R8 init length", n, (2 * INIT - 1) * HALF);
    check(!hiz, "R9 io released in user mode", hiz, 0);
    repeat (20) @(negedge clk);
    check(cs_n && !sck, "R6 flash idle after image", {cs_n, sck}, 2);
    check(per_err == 0, "R3 high phase length", per_err, 0);
    check(idle_err == 0, "R3 clock idle when deselected", idle_err, 0);
    check(dbl_err == 0, "R5 strobe one cycle", dbl_err, 0);
    check(hiz_err == 0, "R9 hiz tracks user mode", hiz_err, 0);
    check(done, "R7 done stays high", done, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    run_image(0);
    run_image(1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule